// File: doc/BRIEF.md
# Post-Modify Address Generator

This unit turns one memory-access request into two results: the effective address that the access uses, and the value the pointer register takes afterwards. Eight addressing modes are supported. Three of them leave the pointer alone or overwrite it: base plus offset, scaled index plus absolute base, and absolute with write-back. Five of them advance it: by an immediate, by the modifier register, by the modifier register with a bit-reversed access address, and two circular modes that keep the pointer inside a buffer.

The circular buffer begins at the address held in a dedicated start register. Its length sits in the low 17 bits of the modifier register. In the register-increment circular mode, the increment is packed into the modifier register above the length and scaled by the element size. A request is presented with `in_valid`. The two results appear on the registered outputs one clock later, together with `out_valid`. The caller owns the register file and writes `ptr_next` back itself.

Top module: `agu_postmod`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. While `in_valid` is low, `eff_addr` and `ptr_next` keep their previous values whatever the other inputs do.
- R2: After reset, `out_valid`, `eff_addr` and `ptr_next` are all zero.
- R3: Mode code 0 (offset): `eff_addr = ptr + imm` and `ptr_next = ptr`.
- R4: Mode code 1 (scaled index): `eff_addr = (idx << shift) + imm` and `ptr_next = ptr`. For example, shift 1 and index 0..3 give offsets 0, 2, 4, 6.
- R5: Mode code 2 (absolute): both `eff_addr` and `ptr_next` equal `imm`.
- R6: Mode code 3 (post-increment by immediate): `ptr_next = ptr + imm`.
- R7: Mode code 4 (post-increment by modifier): `ptr_next = ptr + modreg`.
- R8: Mode code 5 (bit-reversed): `eff_addr` is `ptr[31:16]` followed by `ptr[15:0]` with its bit order reversed, and `ptr_next = ptr + modreg`. For example, a step of 0x2000 from an aligned base gives access offsets 0, 4, 2, 6.
- R9: Mode code 6 (circular, immediate step): with L = `modreg[16:0]` and S = `cstart`, `ptr_next = S + ((ptr - S + imm) mod L)`. For example, L = 2 and step 1 give pointer offsets 1, 0, 1, 0.
- R10: Mode code 7 (circular, packed step): the step is the signed field `modreg[23:17]`, shifted left by 1 when `elem_half` is 1 and used unshifted when it is 0. The wrap rule of R9 applies with that step.
- R11: In both circular modes, a negative step that takes the offset below zero wraps to the top of the buffer. For example, L = 8, offset 1 and step -3 give offset 6.
- R12: In mode codes 3, 4, 6 and 7, `eff_addr` equals the old `ptr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A request is present this cycle |
| mode | input | 3 | Addressing mode code (0..7) |
| ptr | input | 32 | Current pointer register |
| modreg | input | 32 | Modifier register: a step, a length, or a packed length and step |
| cstart | input | 32 | Circular buffer start address |
| imm | input | 32 | Immediate: an offset, a step or an absolute address |
| idx | input | 32 | Index for the scaled-index mode |
| shift | input | 2 | Left shift applied to the index |
| elem_half | input | 1 | Element size: 1 for halfword, 0 for byte |
| out_valid | output | 1 | Results are valid |
| eff_addr | output | 32 | Effective address of the access |
| ptr_next | output | 32 | Updated pointer value |

## Verification
The wrap check assumes a well-formed circular request. The length must be non-zero, the pointer must start inside the buffer, and the step magnitude must not exceed the length. Under those conditions a single add or subtract of the length is enough to land back inside the buffer. The property therefore qualifies its trigger on those conditions rather than assuming them for every request. The stimulus respects them in the same way: every circular sequence starts at the buffer start and uses steps no larger than the length, and each pointer result is fed back as the next pointer.

// File: rtl/agu_pkg.sv
package agu_pkg;

    typedef enum logic [2:0] {
        AM_OFS  = 3'd0,
        AM_IDX  = 3'd1,
        AM_ABS  = 3'd2,
        AM_PINC = 3'd3,
        AM_PMOD = 3'd4,
        AM_BREV = 3'd5,
        AM_CIMM = 3'd6,
        AM_CREG = 3'd7
    } agu_mode_e;

endpackage

// File: rtl/agu_bitrev.sv
module agu_bitrev #(
    parameter int W = 16
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    for (genvar i = 0; i < W; i++) begin : g_rev
        assign dout[i] = din[W-1-i];
    end
endmodule

// File: rtl/agu_circ.sv
module agu_circ #(
    parameter int AW    = 32,
    parameter int LEN_W = 17
) (
    input  logic [AW-1:0]    ptr,
    input  logic [AW-1:0]    start,
    input  logic [AW-1:0]    step,
    input  logic [LEN_W-1:0] len,
    output logic [AW-1:0]    ptr_new
);
    localparam int PAD = AW - LEN_W;

    logic signed [AW-1:0] raw_off;
    logic signed [AW-1:0] len_s;
    logic        [AW-1:0] fixed_off;

    always_comb begin
        len_s   = $signed({{PAD{1'b0}}, len});
        raw_off = $signed(ptr - start + step);
        if (raw_off < 0) begin
            fixed_off = raw_off + len_s;
        end else if (raw_off >= len_s) begin
            fixed_off = raw_off - len_s;
        end else begin
            fixed_off = raw_off;
        end
        ptr_new = start + fixed_off;
    end
endmodule

// File: rtl/agu_postmod.sv
module agu_postmod
    import agu_pkg::*;
#(
    parameter int AW     = 32,
    parameter int BREV_W = 16,
    parameter int LEN_W  = 17,
    parameter int CINC_W = 7,
    parameter int SH_W   = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [2:0]    mode,
    input  logic [AW-1:0] ptr,
    input  logic [AW-1:0] modreg,
    input  logic [AW-1:0] cstart,
    input  logic [AW-1:0] imm,
    input  logic [AW-1:0] idx,
    input  logic [SH_W-1:0] shift,
    input  logic          elem_half,
    output logic          out_valid,
    output logic [AW-1:0] eff_addr,
    output logic [AW-1:0] ptr_next
);
    localparam int CINC_LO = LEN_W;
    localparam int CINC_HI = LEN_W + CINC_W - 1;
    localparam int TOP_W   = AW - BREV_W;

    typedef struct packed {
        logic          vld;
        logic [AW-1:0] ea;
        logic [AW-1:0] np;
    } agu_state_t;

    agu_state_t st_d, st_q;
    agu_mode_e  mode_e;

    logic [BREV_W-1:0] brev_lo;
    logic [AW-1:0]     creg_step;
    logic [AW-1:0]     circ_step;
    logic [AW-1:0]     circ_np;
    logic [LEN_W-1:0]  circ_len;
    logic              unused_hi;

    assign mode_e    = agu_mode_e'(mode);
    assign circ_len  = modreg[LEN_W-1:0];
    assign unused_hi = ^modreg[AW-1:CINC_HI+1];

    agu_bitrev #(.W(BREV_W)) u_brev (
        .din  (ptr[BREV_W-1:0]),
        .dout (brev_lo)
    );

    always_comb begin
        creg_step = {{(AW-CINC_W){modreg[CINC_HI]}}, modreg[CINC_HI:CINC_LO]};
        if (elem_half) begin
            creg_step = creg_step << 1;
        end
        circ_step = (mode_e == AM_CREG) ? creg_step : imm;
    end

    agu_circ #(.AW(AW), .LEN_W(LEN_W)) u_circ (
        .ptr     (ptr),
        .start   (cstart),
        .step    (circ_step),
        .len     (circ_len),
        .ptr_new (circ_np)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            unique case (mode_e)
                AM_OFS: begin
                    st_d.ea = ptr + imm;
                    st_d.np = ptr;
                end
                AM_IDX: begin
                    st_d.ea = (idx << shift) + imm;
                    st_d.np = ptr;
                end
                AM_ABS: begin
                    st_d.ea = imm;
                    st_d.np = imm;
                end
                AM_PINC: begin
                    st_d.ea = ptr;
                    st_d.np = ptr + imm;
                end
                AM_PMOD: begin
                    st_d.ea = ptr;
                    st_d.np = ptr + modreg;
                end
                AM_BREV: begin
                    st_d.ea = {ptr[AW-1:AW-TOP_W], brev_lo};
                    st_d.np = ptr + modreg;
                end
                AM_CIMM, AM_CREG: begin
                    st_d.ea = ptr;
                    st_d.np = circ_np;
                end
                default: begin
                    st_d.ea = st_q.ea;
                    st_d.np = st_q.np;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign eff_addr  = st_q.ea;
    assign ptr_next  = st_q.np;

    // Assertions
    logic [AW-1:0] len_ext;
    assign len_ext = {{(AW-LEN_W){1'b0}}, circ_len};

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R1
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(eff_addr) && $stable(ptr_next))); // R1
    AST_ABS_WRITEBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 3'd2) |=> (ptr_next == eff_addr)); // R5
    AST_OLD_PTR_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (mode == 3'd3 || mode == 3'd4 || mode == 3'd6 || mode == 3'd7))
        |=> (eff_addr == $past(ptr))); // R12
    AST_KEEP_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (mode == 3'd0 || mode == 3'd1)) |=> (ptr_next == $past(ptr))); // R3
    AST_BREV_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 3'd5)
        |=> (eff_addr[AW-1:BREV_W] == $past(ptr[AW-1:BREV_W]))); // R8
    AST_CIRC_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 3'd6 && circ_len != '0 && (ptr - cstart) < len_ext
         && $signed(imm) <= $signed(len_ext) && $signed(imm) >= -$signed(len_ext))
        |=> ((ptr_next - $past(cstart)) < $past(len_ext))); // R9
endmodule

// File: tb/sim_agu_postmod.sv
module sim_agu_postmod;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  mode = '0;
    logic [31:0] ptr = '0, modreg = '0, cstart = '0, imm = '0, idx = '0;
    logic [1:0]  shift = '0;
    logic        elem_half = 1'b0;
    logic        out_valid;
    logic [31:0] eff_addr, ptr_next;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    typedef struct {
        logic [31:0] ea;
        logic [31:0] np;
        string       req;
    } exp_t;
    exp_t sbq[$];
    logic [31:0] last_ea, last_np;
    logic [31:0] cur_ptr;

    localparam logic [31:0] BUF = 32'h0001_0000;

    always #5 clk = ~clk;

    agu_postmod u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .ptr(ptr), .modreg(modreg), .cstart(cstart), .imm(imm), .idx(idx),
        .shift(shift), .elem_half(elem_half), .out_valid(out_valid),
        .eff_addr(eff_addr), .ptr_next(ptr_next)
    );

    function automatic logic [31:0] wrap(input logic [31:0] p, input logic [31:0] s,
                                         input longint stp, input logic [31:0] mr);
        longint len = longint'(mr[16:0]);
        longint off = longint'(p - s) + stp;
        while (off < 0) off += len;
        off = off % len;
        return s + 32'(off);
    endfunction

    task automatic send(input int m, input logic [31:0] p, input logic [31:0] mr,
                        input logic [31:0] cs, input logic [31:0] im, input logic [31:0] ix,
                        input int sh, input logic hw, input string req);
        exp_t e;
        longint stp;
        e.req = req;
        case (m)
            0: begin e.ea = p + im; e.np = p; end
            1: begin e.ea = ix * (32'd1 << sh) + im; e.np = p; end
            2: begin e.ea = im; e.np = im; end
            3: begin e.ea = p; e.np = p + im; end
            4: begin e.ea = p; e.np = p + mr; end
            5: begin
                e.ea = p;
                for (int b = 0; b < 16; b++) e.ea[b] = p[15-b];
                e.np = p + mr;
            end
            6: begin e.ea = p; e.np = wrap(p, cs, longint'($signed(im)), mr); end
            default: begin
                stp = longint'($signed(mr[23:17])) * (hw ? 2 : 1);
                e.ea = p; e.np = wrap(p, cs, stp, mr);
            end
        endcase
        sbq.push_back(e);
        cur_ptr = e.np;
        in_valid = 1'b1; mode = 3'(m); ptr = p; modreg = mr; cstart = cs;
        imm = im; idx = ix; shift = 2'(sh); elem_half = hw;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Monitor: pops the scoreboard when a result appears
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            exp_t e;
            checks++;
            if (sbq.size() == 0) begin
                fails++;
                $display("FAIL R1: unexpected out_valid, actual 1 expected 0");
            end else begin
                e = sbq.pop_front();
                last_ea = e.ea; last_np = e.np;
                if (eff_addr !== e.ea || ptr_next !== e.np) begin
                    fails++;
                    $display("FAIL %s: actual ea=%h np=%h expected ea=%h np=%h",
                             e.req, eff_addr, ptr_next, e.ea, e.np);
                end
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++; // R2 reset state
        if (out_valid !== 1'b0 || eff_addr !== '0 || ptr_next !== '0) begin
            fails++;
            $display("FAIL R2: actual %b/%h/%h expected 0/0/0", out_valid, eff_addr, ptr_next);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R3 offset mode, byte and halfword strides
        for (int k = 0; k < 4; k++) send(0, BUF, 0, 0, 32'(k), 0, 0, 0, "R3");
        for (int k = 0; k < 4; k++) send(0, BUF, 0, 0, 32'(2*k), 0, 0, 1, "R3");
        // R4 scaled index with absolute base
        for (int k = 0; k < 4; k++) send(1, 32'h55, 0, 0, BUF, 32'(k), 1, 0, "R4");
        send(1, 32'h55, 0, 0, BUF, 32'h3, 3, 0, "R4");
        // R5 absolute with write-back
        for (int k = 0; k < 4; k++) send(2, 32'hdead, 0, 0, BUF + 32'(2*k), 0, 0, 1, "R5");
        // R6 / R12 post-increment by immediate
        cur_ptr = BUF;
        for (int k = 0; k < 4; k++) send(3, cur_ptr, 0, 0, 32'd2, 0, 0, 1, "R6 R12");
        send(3, cur_ptr, 0, 0, 32'hffff_fffe, 0, 0, 1, "R6");
        // R7 post-increment by modifier
        cur_ptr = BUF;
        for (int k = 0; k < 4; k++) send(4, cur_ptr, 32'd1, 0, 0, 0, 0, 0, "R7 R12");
        // R8 bit-reversed: offsets 0,4,2,6
        cur_ptr = BUF;
        for (int k = 0; k < 4; k++) send(5, cur_ptr, 32'h2000, 0, 0, 0, 0, 0, "R8");
        // R9 circular immediate: len 2 step 1, len 4 step 2
        cur_ptr = BUF;
        for (int k = 0; k < 4; k++) send(6, cur_ptr, 32'd2, BUF, 32'd1, 0, 0, 0, "R9 R12");
        cur_ptr = BUF;
        for (int k = 0; k < 4; k++) send(6, cur_ptr, 32'd4, BUF, 32'd2, 0, 0, 1, "R9");
        // R10 circular packed step: byte len2 step1, half len4 step1 (scaled to 2)
        cur_ptr = BUF;
        for (int k = 0; k < 4; k++) send(7, cur_ptr, (32'd1 << 17) | 32'd2, BUF, 0, 0, 0, 0, "R10");
        cur_ptr = BUF;
        for (int k = 0; k < 4; k++) send(7, cur_ptr, (32'd1 << 17) | 32'd4, BUF, 0, 0, 0, 1, "R10");
        // R11 negative step wrap: len 8, offset 1, step -3 -> offset 6
        send(6, BUF + 1, 32'd8, BUF, 32'hffff_fffd, 0, 0, 0, "R11");
        send(7, BUF + 1, (32'h7d << 17) | 32'd8, BUF, 0, 0, 0, 0, "R11");
        send(7, BUF + 2, (32'h7e << 17) | 32'd8, BUF, 0, 0, 0, 1, "R11");
        @(negedge clk);

        // R1 hold: inputs change with in_valid low, outputs must not move
        mode = 3'd2; imm = 32'h1234_5678; ptr = 32'h9; modreg = 32'h77;
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || eff_addr !== last_ea || ptr_next !== last_np) begin
            fails++;
            $display("FAIL R1: actual %b/%h/%h expected 0/%h/%h",
                     out_valid, eff_addr, ptr_next, last_ea, last_np);
        end
        checks++;
        if (sbq.size() != 0) begin
            fails++;
            $display("FAIL R1: actual %0d pending results expected 0", sbq.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule